// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a set of single-bit lock flags that two independent ports share. Software on each side uses the flags to agree on who may touch a shared memory region. A port asks for a flag by writing 0 to it. It then reads the flag back: 0 means the port holds the lock, and 1 means it does not. A port that holds a flag gives it up by writing 1. Each port sees the flag from its own side, so the two ports can read different values for the same flag.

A request for a flag that the other side holds is not lost. It is kept as a waiting claim and is granted in the same update in which the holder lets go. When both ports ask for the same free flag in the same clock, the left port gets it and the right request waits. Reads put the flag value on every bit of the 16-bit data bus.

Each port's semaphore-enable input also drives the output data multiplexer. While it is low, array data never reaches that port's output.

All control is sampled on one clock, and reset is synchronous and active high. A write is recognised when the read/write strobe is sampled low on one clock and high on the next.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free, and a read of any flag returns 16'hFFFF on both ports.
- R2: There are eight flags, chosen by the 3-bit address. An operation on one flag does not change what any other flag reads.
- R3: A read happens when sem_n=0, ce_n=1, rw_n=1 and oe_n=0. During a read, sem_rd is 1 and dout carries the port's view of the flag on all 16 bits: 16'h0000 when this port holds the flag, 16'hFFFF otherwise.
- R4: A write commits only on a clock where rw_n is sampled 1, rw_n was sampled 0 on the clock before, and sem_n=0 and ce_n=1 hold on the committing clock. Its effect shows in reads from the next cycle on. If the rising clock has sem_n=1, the write is ignored.
- R5: A write uses only wdata bit 0, where 0 means claim and 1 means release. Bits 15:1 have no effect.
- R6: A claim of a free flag grants it to the claiming port. That port then reads 0 and the other port reads 1. The two ports never both read 0 for the same flag.
- R7: A release by the holder frees the flag, and both ports then read 1 unless a waiting claim exists.
- R8: A claim of a flag held by the other port is kept as waiting, and the waiting port reads 1. When the holder releases, the flag passes to the waiting port, which reads 0 from the next cycle.
- R9: Claims from both ports to the same free flag on the same committing clock grant the flag to the left port. The right claim is kept waiting.
- R10: A release written by a port that does not hold the flag withdraws that port's waiting claim and leaves the holder unchanged. A claim written by the holder changes nothing.
- R11: With sem_n=0 and ce_n=0, whatever the byte selects, no write commits, sem_rd is 0 and dout is 16'h0000.
- R12: While sem_n=0, dout never shows arr_rdata: it shows the flag view during a read and 16'h0000 otherwise. While sem_n=1, dout equals arr_rdata and sem_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left semaphore enable, active low |
| l_ce_n | input | 1 | Left chip enable, active low (must be high for flag access) |
| l_rw_n | input | 1 | Left read (1) / write (0) strobe |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 16 | Left write data (bit 0 used) |
| l_arr_rdata | input | 16 | Left array read data for the output mux |
| l_dout | output | 16 | Left output data |
| l_sem_rd | output | 1 | Left flag read in progress |
| r_sem_n | input | 1 | Right semaphore enable, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write strobe |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 16 | Right write data (bit 0 used) |
| r_arr_rdata | input | 16 | Right array read data for the output mux |
| r_dout | output | 16 | Right output data |
| r_sem_rd | output | 1 | Right flag read in progress |

## Verification
The assertions assume that reset is high from the first clock edge, that every port input is synchronous to clk, and that each address stays inside the eight flags. The stimulus holds reset from time zero and changes inputs one time unit after a rising edge. It only applies flag indices 0 to 7. It builds each write as a deliberate low-then-high strobe sequence, so that every commit, and every suppressed commit, falls on a clock the reference model can predict.

// File: rtl/sembank_pkg.sv
package sembank_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // One committed write from a port: claim (data 0) or drop (data 1).
    typedef struct packed {
        logic claim;
        logic drop;
    } sem_cmd_t;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } flag_state_t;

    // Per-port view of a flag: 0 only for the holder.
    function automatic logic view_bit(owner_e o, logic is_left);
        return is_left ? (o != OWN_LEFT) : (o != OWN_RIGHT);
    endfunction

    // Drops apply first, then claims become waiting, then a free flag
    // is handed out with the left side first.
    function automatic flag_state_t flag_next(flag_state_t s, sem_cmd_t cl, sem_cmd_t cr);
        flag_state_t n;
        n = s;
        if (cl.drop) begin
            if (n.owner == OWN_LEFT) n.owner = OWN_NONE;
            n.wait_l = 1'b0;
        end
        if (cr.drop) begin
            if (n.owner == OWN_RIGHT) n.owner = OWN_NONE;
            n.wait_r = 1'b0;
        end
        if (cl.claim && n.owner != OWN_LEFT)  n.wait_l = 1'b1;
        if (cr.claim && n.owner != OWN_RIGHT) n.wait_r = 1'b1;
        if (n.owner == OWN_NONE) begin
            if (n.wait_l) begin
                n.owner  = OWN_LEFT;
                n.wait_l = 1'b0;
            end else if (n.wait_r) begin
                n.owner  = OWN_RIGHT;
                n.wait_r = 1'b0;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl
    import sembank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sem_n,
    input  logic     ce_n,
    input  logic     rw_n,
    input  logic     oe_n,
    input  logic     ub_n,
    input  logic     lb_n,
    input  logic     wbit,
    output sem_cmd_t cmd,
    output logic     rd_act
);

    logic rw_q;
    logic forbid;
    logic access;
    logic commit;

    always_ff @(posedge clk) begin
        if (rst) rw_q <= 1'b1;
        else     rw_q <= rw_n;
    end

    // Chip enable together with a flag access and a byte lane is not allowed.
    assign forbid = !ce_n && !sem_n && (!ub_n || !lb_n);
    assign access = !sem_n && ce_n && !forbid;
    assign commit = access && !rw_q && rw_n;

    assign cmd.claim = commit && !wbit;
    assign cmd.drop  = commit &&  wbit;
    assign rd_act    = access && rw_n && !oe_n;

    AST_CMD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (cmd.claim || cmd.drop) |-> ($past(rw_n) == 1'b0 && rw_n && !sem_n)); // R4

    AST_NO_CMD_CE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> (!cmd.claim && !cmd.drop && !rd_act)); // R11

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(cmd.claim && cmd.drop)); // R5

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sembank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sem_cmd_t    cmd_l,
    input  sem_cmd_t    cmd_r,
    output flag_state_t state
);

    flag_state_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.owner  <= OWN_NONE;
            cur.wait_l <= 1'b0;
            cur.wait_r <= 1'b0;
        end else begin
            cur <= flag_next(cur, cmd_l, cmd_r);
        end
    end

    assign state = cur;

    AST_RESET_FREE: assert property (@(posedge clk)
        rst |=> (cur.owner == OWN_NONE && !cur.wait_l && !cur.wait_r)); // R1

    AST_WAIT_L_HELD: assert property (@(posedge clk) disable iff (rst)
        cur.wait_l |-> cur.owner == OWN_RIGHT); // R8

    AST_WAIT_R_HELD: assert property (@(posedge clk) disable iff (rst)
        cur.wait_r |-> cur.owner == OWN_LEFT); // R8

    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
        (cmd_l.claim && cmd_r.claim && cur.owner == OWN_NONE)
        |=> (cur.owner == OWN_LEFT && cur.wait_r)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cmd_l.claim && !cmd_l.drop && !cmd_r.claim && !cmd_r.drop)
        |=> $stable(cur)); // R4

    AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_LEFT && cur.wait_r && cmd_l.drop && !cmd_r.drop)
        |=> cur.owner == OWN_RIGHT); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_RIGHT && cmd_r.drop && !cur.wait_l && !cmd_l.claim)
        |=> cur.owner == OWN_NONE); // R7

endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
    parameter int DATA_W = 16
) (
    input  logic              sem_n,
    input  logic              rd_act,
    input  logic              flag_bit,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dout
);

    always_comb begin
        if (sem_n)       dout = arr_rdata;
        else if (rd_act) dout = {DATA_W{flag_bit}};
        else             dout = '0;
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sembank_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 16,
    localparam int ADDR_W   = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [DATA_W-1:0] l_arr_rdata,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_sem_rd,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic [DATA_W-1:0] r_arr_rdata,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_sem_rd
);

    sem_cmd_t    l_cmd;
    sem_cmd_t    r_cmd;
    logic        l_rd;
    logic        r_rd;
    logic        l_bit;
    logic        r_bit;
    logic        wdata_hi_unused;
    flag_state_t st [NUM_FLAGS];

    // Only bit 0 carries meaning on a flag write.
    assign wdata_hi_unused = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    sem_port_ctrl u_lctl (
        .clk    (clk),
        .rst    (rst),
        .sem_n  (l_sem_n),
        .ce_n   (l_ce_n),
        .rw_n   (l_rw_n),
        .oe_n   (l_oe_n),
        .ub_n   (l_ub_n),
        .lb_n   (l_lb_n),
        .wbit   (l_wdata[0]),
        .cmd    (l_cmd),
        .rd_act (l_rd)
    );

    sem_port_ctrl u_rctl (
        .clk    (clk),
        .rst    (rst),
        .sem_n  (r_sem_n),
        .ce_n   (r_ce_n),
        .rw_n   (r_rw_n),
        .oe_n   (r_oe_n),
        .ub_n   (r_ub_n),
        .lb_n   (r_lb_n),
        .wbit   (r_wdata[0]),
        .cmd    (r_cmd),
        .rd_act (r_rd)
    );

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            sem_cmd_t cl;
            sem_cmd_t cr;
            assign cl = (l_addr == ADDR_W'(g)) ? l_cmd : '0;
            assign cr = (r_addr == ADDR_W'(g)) ? r_cmd : '0;
            sem_flag_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .cmd_l (cl),
                .cmd_r (cr),
                .state (st[g])
            );
        end
    endgenerate

    assign l_bit = view_bit(st[l_addr].owner, 1'b1);
    assign r_bit = view_bit(st[r_addr].owner, 1'b0);

    sem_read_mux #(.DATA_W(DATA_W)) u_lmux (
        .sem_n     (l_sem_n),
        .rd_act    (l_rd),
        .flag_bit  (l_bit),
        .arr_rdata (l_arr_rdata),
        .dout      (l_dout)
    );

    sem_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .sem_n     (r_sem_n),
        .rd_act    (r_rd),
        .flag_bit  (r_bit),
        .arr_rdata (r_arr_rdata),
        .dout      (r_dout)
    );

    assign l_sem_rd = l_rd;
    assign r_sem_rd = r_rd;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (l_sem_rd && r_sem_rd && l_addr == r_addr) |-> (l_dout[0] || r_dout[0])); // R6

    AST_REPLICATE_L: assert property (@(posedge clk) disable iff (rst)
        l_sem_rd |-> (l_dout == '0 || l_dout == '1)); // R3

    AST_REPLICATE_R: assert property (@(posedge clk) disable iff (rst)
        r_sem_rd |-> (r_dout == '0 || r_dout == '1)); // R3

    AST_ARRAY_ISOLATED_L: assert property (@(posedge clk) disable iff (rst)
        (!l_sem_n && !l_sem_rd) |-> l_dout == '0); // R12

    AST_ARRAY_ISOLATED_R: assert property (@(posedge clk) disable iff (rst)
        (!r_sem_n && !r_sem_rd) |-> r_dout == '0); // R12

endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        p_sem_n [2];
    logic        p_ce_n  [2];
    logic        p_rw_n  [2];
    logic        p_oe_n  [2];
    logic        p_ub_n  [2];
    logic        p_lb_n  [2];
    logic [2:0]  p_addr  [2];
    logic [15:0] p_wd    [2];
    logic [15:0] p_arr   [2];
    logic [15:0] l_dout, r_dout;
    logic        l_sem_rd, r_sem_rd;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // Reference model state: holder 0 none, 1 left, 2 right.
    int m_own  [8];
    bit m_wait [2][8];
    bit m_rq   [2];

    sem_bank u_dut (
        .clk(clk), .rst(rst),
        .l_sem_n(p_sem_n[0]), .l_ce_n(p_ce_n[0]), .l_rw_n(p_rw_n[0]), .l_oe_n(p_oe_n[0]),
        .l_ub_n(p_ub_n[0]), .l_lb_n(p_lb_n[0]), .l_addr(p_addr[0]), .l_wdata(p_wd[0]),
        .l_arr_rdata(p_arr[0]), .l_dout(l_dout), .l_sem_rd(l_sem_rd),
        .r_sem_n(p_sem_n[1]), .r_ce_n(p_ce_n[1]), .r_rw_n(p_rw_n[1]), .r_oe_n(p_oe_n[1]),
        .r_ub_n(p_ub_n[1]), .r_lb_n(p_lb_n[1]), .r_addr(p_addr[1]), .r_wdata(p_wd[1]),
        .r_arr_rdata(p_arr[1]), .r_dout(r_dout), .r_sem_rd(r_sem_rd)
    );

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit exp_rd(int p);
        return p_sem_n[p] == 1'b0 && p_ce_n[p] == 1'b1 && p_rw_n[p] == 1'b1 && p_oe_n[p] == 1'b0;
    endfunction

    function automatic logic [15:0] exp_dout(int p);
        if (p_sem_n[p]) return p_arr[p];
        if (!exp_rd(p)) return 16'h0000;
        return (m_own[p_addr[p]] == p + 1) ? 16'h0000 : 16'hFFFF;
    endfunction

    task automatic model_clock();
        bit c [2];
        bit v [2];
        int a [2];
        for (int p = 0; p < 2; p++) begin
            c[p] = p_sem_n[p] == 1'b0 && p_ce_n[p] == 1'b1 && m_rq[p] == 1'b0 && p_rw_n[p] == 1'b1;
            v[p] = p_wd[p][0];
            a[p] = int'(p_addr[p]);
        end
        for (int p = 0; p < 2; p++) m_rq[p] = p_rw_n[p];
        if (rst) begin
            for (int f = 0; f < 8; f++) begin
                m_own[f] = 0; m_wait[0][f] = 0; m_wait[1][f] = 0;
            end
            m_rq[0] = 1; m_rq[1] = 1;
            return;
        end
        for (int p = 0; p < 2; p++)
            if (c[p] && v[p]) begin
                if (m_own[a[p]] == p + 1) m_own[a[p]] = 0;
                m_wait[p][a[p]] = 0;
            end
        for (int p = 0; p < 2; p++)
            if (c[p] && !v[p] && m_own[a[p]] != p + 1) m_wait[p][a[p]] = 1;
        for (int f = 0; f < 8; f++)
            if (m_own[f] == 0) begin
                if (m_wait[0][f]) begin m_own[f] = 1; m_wait[0][f] = 0; end
                else if (m_wait[1][f]) begin m_own[f] = 2; m_wait[1][f] = 0; end
            end
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) begin
            chk("left dout", l_dout, exp_dout(0));
            chk("left sem_rd", {15'd0, l_sem_rd}, {15'd0, exp_rd(0)});
            chk("right dout", r_dout, exp_dout(1));
            chk("right sem_rd", {15'd0, r_sem_rd}, {15'd0, exp_rd(1)});
        end
        @(posedge clk);
        model_clock();
        #1;
    endtask

    task automatic drive(int p, bit sem, bit ce, bit rw, bit oe, bit ub, bit lb, int addr, logic [15:0] wd);
        p_sem_n[p] = sem; p_ce_n[p] = ce; p_rw_n[p] = rw; p_oe_n[p] = oe;
        p_ub_n[p] = ub; p_lb_n[p] = lb; p_addr[p] = 3'(addr); p_wd[p] = wd;
    endtask

    task automatic idle(int p);
        drive(p, 1, 1, 1, 1, 1, 1, 0, 16'h0000);
    endtask

    task automatic sem_wr(int p, int addr, logic [15:0] wd);
        drive(p, 0, 1, 0, 1, 1, 1, addr, wd); step();
        drive(p, 0, 1, 1, 1, 1, 1, addr, wd); step();
        idle(p);
    endtask

    task automatic read_both(int addr);
        drive(0, 0, 1, 1, 0, 1, 1, addr, 16'h0000);
        drive(1, 0, 1, 1, 0, 1, 1, addr, 16'h0000);
        step();
        idle(0); idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        p_arr[0] = 16'hA5C3; p_arr[1] = 16'h3C96;
        idle(0); idle(1);
        for (int f = 0; f < 8; f++) begin
            m_own[f] = 0; m_wait[0][f] = 0; m_wait[1][f] = 0;
        end
        m_rq[0] = 1; m_rq[1] = 1;
        step(); step(); step();
        rst = 1'b0;
        step();

        cur_req = "R1";
        for (int f = 0; f < 8; f++) read_both(f);

        cur_req = "R5";  // claim with upper bits set: only bit 0 counts
        sem_wr(0, 3, 16'hFFFE);
        cur_req = "R6";
        read_both(3);
        cur_req = "R2";
        read_both(2); read_both(4);

        cur_req = "R8";
        sem_wr(1, 3, 16'h0000);
        read_both(3);
        sem_wr(0, 3, 16'h0001);  // release hands flag to waiting right port
        read_both(3);

        cur_req = "R7";
        sem_wr(1, 3, 16'hFFFF);
        read_both(3);

        cur_req = "R9";
        drive(0, 0, 1, 0, 1, 1, 1, 5, 16'h0000);
        drive(1, 0, 1, 0, 1, 1, 1, 5, 16'h0000);
        step();
        p_rw_n[0] = 1; p_rw_n[1] = 1;
        step();
        idle(0); idle(1);
        read_both(5);

        cur_req = "R10";
        sem_wr(1, 5, 16'h0001);  // right withdraws its waiting claim
        read_both(5);
        sem_wr(0, 5, 16'h0000);  // holder claims again: no change
        read_both(5);
        sem_wr(0, 5, 16'h0001);  // release: nobody waiting
        read_both(5);

        cur_req = "R11";
        drive(0, 0, 0, 0, 1, 0, 0, 1, 16'h0000); step();
        drive(0, 0, 0, 1, 0, 0, 0, 1, 16'h0000); step();
        drive(0, 0, 0, 1, 0, 1, 1, 1, 16'h0000); step();
        idle(0);
        read_both(1);

        cur_req = "R4";
        drive(0, 0, 1, 0, 1, 1, 1, 6, 16'h0000); step();
        drive(0, 1, 1, 1, 1, 1, 1, 6, 16'h0000); step();  // rise with sem high
        idle(0);
        read_both(6);
        drive(0, 0, 1, 0, 1, 1, 1, 6, 16'h0000); step(); step(); step();
        drive(0, 0, 1, 1, 1, 1, 1, 6, 16'h0000); step();
        idle(0);
        read_both(6);
        sem_wr(0, 6, 16'h0001);
        read_both(6);

        cur_req = "R12";
        drive(0, 1, 0, 1, 0, 1, 1, 0, 16'h0000);
        drive(1, 1, 0, 1, 0, 1, 1, 0, 16'h0000);
        step();
        p_arr[0] = 16'h0F0F; p_arr[1] = 16'hF00F;
        step();
        drive(0, 0, 1, 1, 1, 1, 1, 0, 16'h0000);
        drive(1, 0, 1, 0, 0, 1, 1, 0, 16'h0000);
        step();
        drive(1, 0, 1, 1, 1, 1, 1, 0, 16'h0001); step();  // right releases flag 0 it never held
        idle(0); idle(1);

        cur_req = "R2";
        for (int f = 0; f < 8; f++) sem_wr(f % 2, f, 16'h0000);
        for (int f = 0; f < 8; f++) read_both(f);

        cur_req = "R3";
        drive(0, 0, 1, 1, 0, 1, 1, 0, 16'h0000);
        drive(1, 0, 1, 1, 0, 1, 1, 7, 16'h0000);
        step();
        idle(0); idle(1);
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule